// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit

This block sits between a processor's datapath and a 32-bit data memory organised as four byte lanes. On a store it turns the access size and the two low address bits into a per-lane write-enable mask. It also places the source register bytes on the lanes that the mask opens, so that the memory only has to honour the mask.

On a load it takes the full word read from memory. Using the offset and the access kind, it picks out the addressed byte or halfword and widens it to 32 bits, with sign or zero fill as the kind asks. Both paths are purely combinational and share no state, so a single-cycle core can use the store path and the load path in the same cycle. Size and signedness codes match the 3-bit function field of the store and load instructions, so the decoder can pass that field through unchanged.

Top module: `lsu_byte_lane`

## Requirements
- R1: While `st_en` is 0, `st_mask` is 4'b0000 whatever the other store inputs are.
- R2: A byte store (`st_kind` = 3'b000) produces the mask 4'b0001 shifted left by `st_ofs`. Offset 0 opens lane 0 (bits [7:0]) and offset 3 opens lane 3 (bits [31:24]).
- R3: On a byte store, `st_data` carries `st_src[7:0]` in all four lanes.
- R4: A halfword store (`st_kind` = 3'b001) produces mask 4'b0011 when `st_ofs[1]` is 0 and 4'b1100 when it is 1. `st_ofs[0]` has no effect on it.
- R5: On a halfword store, `st_data` carries `st_src[15:0]` in both halves.
- R6: A word store (`st_kind` = 3'b010) produces mask 4'b1111, and `st_data` equals `st_src` for any offset.
- R7: Any other `st_kind` value produces mask 4'b0000, even with `st_en` high.
- R8: A signed byte load (`ld_kind` = 3'b000) returns `ld_word[8k+7:8k]` for offset k, with the upper 24 bits copied from its bit 7.
- R9: An unsigned byte load (`ld_kind` = 3'b100) returns the same lane with the upper 24 bits zero.
- R10: A signed halfword load (`ld_kind` = 3'b001) returns `ld_word[15:0]` when `ld_ofs[1]` is 0 and `ld_word[31:16]` when it is 1. The upper 16 bits are copied from the halfword's bit 15, and `ld_ofs[0]` has no effect.
- R11: An unsigned halfword load (`ld_kind` = 3'b101) selects the same halfword with the upper 16 bits zero.
- R12: A word load (`ld_kind` = 3'b010) returns `ld_word` unchanged for any offset.
- R13: Any other `ld_kind` value returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_en | input | 1 | Store request; a low level closes every lane |
| st_kind | input | 3 | Store size code (000 byte, 001 half, 010 word) |
| st_ofs | input | 2 | Low two bits of the store's effective address |
| st_src | input | 32 | Source register value to be stored |
| st_mask | output | 4 | Per-lane write enable, bit i for bits [8i+7:8i] |
| st_data | output | 32 | Lane-aligned write data |
| ld_kind | input | 3 | Load code (000 lb, 001 lh, 010 lw, 100 lbu, 101 lhu) |
| ld_ofs | input | 2 | Low two bits of the load's effective address |
| ld_word | input | 32 | Raw word read from memory |
| ld_result | output | 32 | Selected and extended load value |

## Verification
The assertions run on every evaluation of the outputs. They check the mask population for each store size, that a disabled store opens no lane, and that the addressed lane of the write data holds the source byte or halfword. They also check that the fill bits of byte and halfword loads are all zero or all equal to the sign bit. Only the bench's scenarios can show that the fill and the lane are the right ones for a given offset. The same holds for the exact mask position for each offset, that the unused offset bit is ignored, and that unknown codes give zero results. The bench covers these with data patterns whose lanes differ in value and in sign.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    // Store size codes, equal to the store function field
    typedef enum logic [2:0] {
        ST_BYTE = 3'b000,
        ST_HALF = 3'b001,
        ST_WORD = 3'b010
    } st_kind_e;

    // Load codes, equal to the load function field
    typedef enum logic [2:0] {
        LD_BYTE  = 3'b000,
        LD_HALF  = 3'b001,
        LD_WORD  = 3'b010,
        LD_BYTEU = 3'b100,
        LD_HALFU = 3'b101
    } ld_kind_e;

    localparam int LANE_W = 8;
    localparam int HALF_W = 16;

endpackage

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / LANE_W,
    parameter int OFS_W  = $clog2(LANES)
) (
    input  logic              en,
    input  logic [2:0]        kind,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  mask,
    output logic [DATA_W-1:0] wdata
);

    localparam int HALVES = DATA_W / HALF_W;

    typedef struct packed {
        logic [LANES-1:0]  mask;
        logic [DATA_W-1:0] data;
    } st_out_t;

    logic [DATA_W-1:0] byte_rep;
    logic [DATA_W-1:0] half_rep;
    logic [OFS_W-1:0]  half_base;
    st_out_t           st_d;

    // Copy the low byte / halfword into every lane / half
    for (genvar g = 0; g < LANES; g++) begin : g_byte_rep
        assign byte_rep[g*LANE_W +: LANE_W] = src[LANE_W-1:0];
    end
    for (genvar g = 0; g < HALVES; g++) begin : g_half_rep
        assign half_rep[g*HALF_W +: HALF_W] = src[HALF_W-1:0];
    end

    // First lane of the addressed halfword; the odd-byte bit is dropped
    assign half_base = {ofs[OFS_W-1:1], 1'b0};

    always_comb begin
        st_d = '0;
        case (kind)
            ST_BYTE: begin
                st_d.mask = LANES'(1) << ofs;
                st_d.data = byte_rep;
            end
            ST_HALF: begin
                st_d.mask = LANES'(3) << half_base;
                st_d.data = half_rep;
            end
            ST_WORD: begin
                st_d.mask = '1;
                st_d.data = src;
            end
            default: begin
                st_d.mask = '0;
                st_d.data = src;
            end
        endcase
        if (!en) begin
            st_d.mask = '0;
        end
    end

    assign mask  = st_d.mask;
    assign wdata = st_d.data;

endmodule

// File: rtl/lsu_load_lane.sv
module lsu_load_lane
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / LANE_W,
    parameter int OFS_W  = $clog2(LANES)
) (
    input  logic [2:0]        kind,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] result
);

    typedef struct packed {
        logic [LANE_W-1:0] b_sel;
        logic [HALF_W-1:0] h_sel;
        logic [DATA_W-1:0] res;
    } ld_out_t;

    ld_out_t ld_d;

    always_comb begin
        ld_d       = '0;
        ld_d.b_sel = word[{ofs, 3'b000} +: LANE_W];
        ld_d.h_sel = word[{ofs[OFS_W-1:1], 4'b0000} +: HALF_W];
        case (kind)
            LD_BYTE:  ld_d.res = {{(DATA_W-LANE_W){ld_d.b_sel[LANE_W-1]}}, ld_d.b_sel};
            LD_BYTEU: ld_d.res = {{(DATA_W-LANE_W){1'b0}}, ld_d.b_sel};
            LD_HALF:  ld_d.res = {{(DATA_W-HALF_W){ld_d.h_sel[HALF_W-1]}}, ld_d.h_sel};
            LD_HALFU: ld_d.res = {{(DATA_W-HALF_W){1'b0}}, ld_d.h_sel};
            LD_WORD:  ld_d.res = word;
            default:  ld_d.res = '0;
        endcase
    end

    assign result = ld_d.res;

endmodule

// File: rtl/lsu_byte_lane.sv
module lsu_byte_lane
    import lsu_pkg::*;
(
    input  logic        st_en,
    input  logic [2:0]  st_kind,
    input  logic [1:0]  st_ofs,
    input  logic [31:0] st_src,
    output logic [3:0]  st_mask,
    output logic [31:0] st_data,
    input  logic [2:0]  ld_kind,
    input  logic [1:0]  ld_ofs,
    input  logic [31:0] ld_word,
    output logic [31:0] ld_result
);

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int OFS_W  = $clog2(LANES);

    lsu_store_lane #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .OFS_W  (OFS_W)
    ) store_i (
        .en    (st_en),
        .kind  (st_kind),
        .ofs   (st_ofs),
        .src   (st_src),
        .mask  (st_mask),
        .wdata (st_data)
    );

    lsu_load_lane #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .OFS_W  (OFS_W)
    ) load_i (
        .kind   (ld_kind),
        .ofs    (ld_ofs),
        .word   (ld_word),
        .result (ld_result)
    );

    // Store-side checks against the unit's outputs
    always_comb begin
        // R1
        st_idle_chk: assert (st_en || st_mask == 4'b0000)
            else $error("mask open while store disabled");
        if (st_en && st_kind == ST_BYTE) begin
            // R2
            st_byte_mask_chk: assert ($countones(st_mask) == 1 && st_mask[st_ofs])
                else $error("byte store mask %b", st_mask);
            // R3
            st_byte_data_chk: assert (st_data[{st_ofs, 3'b000} +: 8] == st_src[7:0])
                else $error("byte store lane data wrong");
        end
        if (st_en && st_kind == ST_HALF) begin
            // R4
            st_half_mask_chk: assert ($countones(st_mask) == 2 && st_mask[{st_ofs[1], 1'b0}])
                else $error("half store mask %b", st_mask);
            // R5
            st_half_data_chk: assert (st_data[{st_ofs[1], 4'b0000} +: 16] == st_src[15:0])
                else $error("half store lane data wrong");
        end
        // R6
        st_word_chk: assert (!(st_en && st_kind == ST_WORD) || (st_mask == 4'b1111 && st_data == st_src))
            else $error("word store wrong");
    end

    // Load-side checks on the fill bits
    always_comb begin
        // R8
        ld_sbyte_fill_chk: assert (ld_kind != LD_BYTE ||
                                   ld_result[31:8] == {24{ld_result[7]}})
            else $error("signed byte fill wrong");
        // R9
        ld_ubyte_fill_chk: assert (ld_kind != LD_BYTEU || ld_result[31:8] == 24'h0)
            else $error("unsigned byte fill wrong");
        // R10
        ld_shalf_fill_chk: assert (ld_kind != LD_HALF ||
                                   ld_result[31:16] == {16{ld_result[15]}})
            else $error("signed half fill wrong");
        // R11
        ld_uhalf_fill_chk: assert (ld_kind != LD_HALFU || ld_result[31:16] == 16'h0)
            else $error("unsigned half fill wrong");
        // R12
        ld_word_pass_chk: assert (ld_kind != LD_WORD || ld_result == ld_word)
            else $error("word load altered");
    end

endmodule

// File: tb/lsu_byte_lane_tb.sv
module lsu_byte_lane_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_en = 1'b0;
    logic [2:0]  st_kind = 3'b000;
    logic [1:0]  st_ofs = 2'b00;
    logic [31:0] st_src = 32'h0;
    logic [3:0]  st_mask;
    logic [31:0] st_data;
    logic [2:0]  ld_kind = 3'b010;
    logic [1:0]  ld_ofs = 2'b00;
    logic [31:0] ld_word = 32'h0;
    logic [31:0] ld_result;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    lsu_byte_lane dut_i (
        .st_en     (st_en),
        .st_kind   (st_kind),
        .st_ofs    (st_ofs),
        .st_src    (st_src),
        .st_mask   (st_mask),
        .st_data   (st_data),
        .ld_kind   (ld_kind),
        .ld_ofs    (ld_ofs),
        .ld_word   (ld_word),
        .ld_result (ld_result)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_st(input logic en, input logic [2:0] k, input logic [1:0] o,
                            input logic [31:0] s);
        @(posedge clk);
        #1;
        st_en = en; st_kind = k; st_ofs = o; st_src = s;
        @(negedge clk);
    endtask

    task automatic drive_ld(input logic [2:0] k, input logic [1:0] o, input logic [31:0] w);
        @(posedge clk);
        #1;
        ld_kind = k; ld_ofs = o; ld_word = w;
        @(negedge clk);
    endtask

    task automatic t_idle();
        @(negedge clk);
        chk("R1 idle mask", {28'h0, st_mask}, 32'h0);
        chk("R12 idle word load", ld_result, 32'h0);
    endtask

    task automatic t_store_off();
        for (int k = 0; k < 3; k++) begin
            drive_st(1'b0, 3'(k), 2'(k + 1), 32'hFFFF_FFFF);
            chk("R1 disabled store", {28'h0, st_mask}, 32'h0);
        end
    endtask

    task automatic t_store_byte();
        for (int o = 0; o < 4; o++) begin
            drive_st(1'b1, 3'b000, 2'(o), 32'h1234_56A7);
            chk("R2 byte mask", {28'h0, st_mask}, 32'(4'b0001 << o));
            chk("R3 byte data", st_data, 32'hA7A7_A7A7);
        end
    endtask

    task automatic t_store_half();
        drive_st(1'b1, 3'b001, 2'b00, 32'hDEAD_8C3F);
        chk("R4 half mask lo", {28'h0, st_mask}, 32'h3);
        chk("R5 half data", st_data, 32'h8C3F_8C3F);
        drive_st(1'b1, 3'b001, 2'b01, 32'hDEAD_8C3F);
        chk("R4 half mask odd lo", {28'h0, st_mask}, 32'h3);
        drive_st(1'b1, 3'b001, 2'b10, 32'h0000_5501);
        chk("R4 half mask hi", {28'h0, st_mask}, 32'hC);
        chk("R5 half data hi", st_data, 32'h5501_5501);
        drive_st(1'b1, 3'b001, 2'b11, 32'h0000_5501);
        chk("R4 half mask odd hi", {28'h0, st_mask}, 32'hC);
    endtask

    task automatic t_store_word();
        for (int o = 0; o < 4; o++) begin
            drive_st(1'b1, 3'b010, 2'(o), 32'h89AB_CDEF);
            chk("R6 word mask", {28'h0, st_mask}, 32'hF);
            chk("R6 word data", st_data, 32'h89AB_CDEF);
        end
    endtask

    task automatic t_store_bad();
        for (int k = 3; k < 8; k++) begin
            drive_st(1'b1, 3'(k), 2'b00, 32'hFFFF_FFFF);
            chk("R7 unknown store code", {28'h0, st_mask}, 32'h0);
        end
    endtask

    task automatic t_load_byte();
        logic [31:0] w = 32'h80_7F_C3_11;
        logic [7:0]  b;
        for (int o = 0; o < 4; o++) begin
            b = w[8*o +: 8];
            drive_ld(3'b000, 2'(o), w);
            chk("R8 signed byte", ld_result, {{24{b[7]}}, b});
            drive_ld(3'b100, 2'(o), w);
            chk("R9 unsigned byte", ld_result, {24'h0, b});
        end
    endtask

    task automatic t_load_half();
        logic [31:0] w = 32'h7ABC_9001;
        drive_ld(3'b001, 2'b00, w);
        chk("R10 signed half lo", ld_result, 32'hFFFF_9001);
        drive_ld(3'b001, 2'b01, w);
        chk("R10 signed half odd", ld_result, 32'hFFFF_9001);
        drive_ld(3'b001, 2'b10, w);
        chk("R10 signed half hi", ld_result, 32'h0000_7ABC);
        drive_ld(3'b101, 2'b00, w);
        chk("R11 unsigned half lo", ld_result, 32'h0000_9001);
        drive_ld(3'b101, 2'b11, 32'hF00D_0000);
        chk("R11 unsigned half hi", ld_result, 32'h0000_F00D);
    endtask

    task automatic t_load_word();
        for (int o = 0; o < 4; o++) begin
            drive_ld(3'b010, 2'(o), 32'hC001_D00D);
            chk("R12 word load", ld_result, 32'hC001_D00D);
        end
    endtask

    task automatic t_load_bad();
        logic [2:0] codes[3] = '{3'b011, 3'b110, 3'b111};
        foreach (codes[i]) begin
            drive_ld(codes[i], 2'b01, 32'hFFFF_FFFF);
            chk("R13 unknown load code", ld_result, 32'h0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_store_off();
        t_store_byte();
        t_store_half();
        t_store_word();
        t_store_bad();
        t_load_byte();
        t_load_half();
        t_load_word();
        t_load_bad();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule